// File: doc/BRIEF.md
# Hash Bucket Node List Walker

The walker takes one probe at a time from a dispatcher queue. Each probe carries a key that has already been hashed, the byte address of the hash bucket the key maps to, and a tag that identifies the probe. The walker reads the bucket header, which holds an item count and the first node of the bucket. It then follows the singly linked node chain in memory and compares every node key with the probe key. Each equal node produces one match record, made of the probe tag and the node's payload word, which goes to a downstream writer. A match does not end the walk: it continues until a node's next pointer is null.

Memory is reached through one word read port. The port has a request handshake and a response that arrives after a variable latency. Each read depends on the data returned by the read before it, so the walker keeps exactly one read in flight. A per-probe mode bit changes the meaning of the node key field: in that mode the field holds the address of a table row, and one extra read fetches the actual key from that row. The walker accepts the next probe only after the current bucket is finished and its last record has been delivered.

Top module: `bucket_walker`

## Requirements
- R1: While reset is active and directly after it, `idle` and `inReady` are high, and `memReqValid` and `outValid` are low.
- R2: A probe is accepted only when `inReady` is high, and `inReady` equals `idle`. `inReady` is low from the cycle after acceptance until the walk ends.
- R3: The first read of a walk is at the bucket address. Bits [15:0] of the header word hold the item count, and the upper bits are other status. A count of zero ends the walk after that single read, with no record, whatever the rest of the header contains.
- R4: When the count is non-zero, the first node is embedded in the header at bucket+8. Its key is at bucket+8, its next pointer at bucket+16 and its payload at bucket+24, so no pointer is dereferenced to reach it. All request addresses are multiples of 8.
- R5: An ordinary node at address A holds its key at A+0, its next pointer at A+8 and its payload at A+16. The walk follows next pointers until it reads a next pointer whose full 64-bit word is zero.
- R6: Every node whose key equals the probe key produces one record on `outTag`/`outPayload`, carrying the probe tag and the node payload. Records leave in list order, and the walk continues after a match.
- R7: With `cfgKeyPtr`=1, sampled when the probe is accepted, the node key field is a row address. One extra read at that address fetches the key that is compared. Changing `cfgKeyPtr` during a walk has no effect on that walk.
- R8: The payload word is read only for matching nodes. A walk of N nodes (N > 0) therefore takes 1 + N×(2 + m) + h reads, where m is 1 in key-pointer mode and 0 otherwise, and h is the number of matches.
- R9: A memory request holds its address stable until `memReqReady` is high. Only one read is outstanding at a time, and responses may arrive one or more cycles after acceptance.
- R10: While `outReady` is low, a presented record stays stable. No record is lost or duplicated. `idle` rises only after the last record of the bucket has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgKeyPtr | input | 1 | Node key field holds a row address (sampled on accept) |
| inValid | input | 1 | Queue entry valid |
| inReady | output | 1 | Walker can accept an entry |
| inKey | input | DATA_W | Probe key |
| inBucket | input | ADDR_W | Bucket header byte address |
| inTag | input | TAG_W | Probe tag |
| idle | output | 1 | No walk in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Read data word |
| outValid | output | 1 | Match record valid |
| outReady | input | 1 | Writer accepts the record |
| outTag | output | TAG_W | Probe tag of the record |
| outPayload | output | DATA_W | Payload of the matching node |

## Verification
Two events can share one clock edge. One is the handshake of a pending record at the output. The other is the loading of the next record from a following matching node into the same output register. The bench makes this happen with runs of adjacent matching nodes, short random memory latencies and a randomly toggling `outReady`. It judges the result by comparing the exact sequence of received records, and the number of memory reads, against a list that bench functions build from the bucket contents. A lost record, a duplicated record or a record out of order therefore shows up as a count or content mismatch.

// File: rtl/bwalk_pkg.sv
package bwalk_pkg;

  // Byte offsets inside a node and inside the bucket header
  localparam int unsigned HDR_NODE_OFS = 8;
  localparam int unsigned NEXT_OFS     = 8;
  localparam int unsigned PAY_OFS      = 16;

  typedef enum logic [2:0] {
    SEL_HDR,
    SEL_KEY,
    SEL_ROW,
    SEL_NEXT,
    SEL_PAY
  } addrSel_e;

  typedef struct packed {
    logic     loadEntry;
    logic     enterHdr;
    logic     followNext;
    logic     capRow;
    logic     capPay;
    logic     loadOut;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/bwalk_dp.sv
module bwalk_dp
  import bwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] inKey,
  input  logic [ADDR_W-1:0] inBucket,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              outReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outPayload,
  output logic              stKeyMatch,
  output logic              stCountZero,
  output logic              stNextNull,
  output logic              stOutFree
);

  localparam logic [ADDR_W-1:0] HDR_A  = ADDR_W'(HDR_NODE_OFS);
  localparam logic [ADDR_W-1:0] NEXT_A = ADDR_W'(NEXT_OFS);
  localparam logic [ADDR_W-1:0] PAY_A  = ADDR_W'(PAY_OFS);

  logic [DATA_W-1:0] probeKey;
  logic [TAG_W-1:0]  probeTag;
  logic [ADDR_W-1:0] bucketAddr;
  logic [ADDR_W-1:0] nodePtr;
  logic [ADDR_W-1:0] rowPtr;
  logic [DATA_W-1:0] payHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      probeKey   <= '0;
      probeTag   <= '0;
      bucketAddr <= '0;
      nodePtr    <= '0;
      rowPtr     <= '0;
      payHold    <= '0;
    end else begin
      if (strb.loadEntry) begin
        probeKey   <= inKey;
        probeTag   <= inTag;
        bucketAddr <= inBucket;
      end
      if (strb.enterHdr) begin
        nodePtr <= bucketAddr + HDR_A;
      end else if (strb.followNext) begin
        nodePtr <= memRspData[ADDR_W-1:0];
      end
      if (strb.capRow) begin
        rowPtr <= memRspData[ADDR_W-1:0];
      end
      if (strb.capPay) begin
        payHold <= memRspData;
      end
    end
  end

  // Output record register: a new load wins over a same-edge handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outTag     <= '0;
      outPayload <= '0;
    end else if (strb.loadOut) begin
      outValid   <= 1'b1;
      outTag     <= probeTag;
      outPayload <= payHold;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_comb begin
    unique case (strb.addrSel)
      SEL_HDR:  memReqAddr = bucketAddr;
      SEL_KEY:  memReqAddr = nodePtr;
      SEL_ROW:  memReqAddr = rowPtr;
      SEL_NEXT: memReqAddr = nodePtr + NEXT_A;
      SEL_PAY:  memReqAddr = nodePtr + PAY_A;
      default:  memReqAddr = bucketAddr;
    endcase
  end

  assign stKeyMatch  = (memRspData == probeKey);
  assign stCountZero = (memRspData[CNT_W-1:0] == '0);
  assign stNextNull  = (memRspData == '0);
  assign stOutFree   = !outValid || outReady;

endmodule

// File: rtl/bwalk_ctrl.sv
module bwalk_ctrl
  import bwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        cfgKeyPtr,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        stKeyMatch,
  input  logic        stCountZero,
  input  logic        stNextNull,
  input  logic        stOutFree,
  output logic        inReady,
  output logic        idle,
  output logic        memReqValid,
  output ctrlStrobe_t strb
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_HDR_REQ,
    S_HDR_WAIT,
    S_KEY_REQ,
    S_KEY_WAIT,
    S_ROW_REQ,
    S_ROW_WAIT,
    S_PAY_REQ,
    S_PAY_WAIT,
    S_EMIT,
    S_NEXT_REQ,
    S_NEXT_WAIT,
    S_DRAIN
  } walkState_e;

  walkState_e state, nxt;
  logic       keyPtrMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      keyPtrMode <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.loadEntry) begin
        keyPtrMode <= cfgKeyPtr;
      end
    end
  end

  always_comb begin
    nxt          = state;
    strb         = '0;
    strb.addrSel = SEL_HDR;
    memReqValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (inValid) begin
          strb.loadEntry = 1'b1;
          nxt            = S_HDR_REQ;
        end
      end
      S_HDR_REQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_HDR;
        if (memReqReady) nxt = S_HDR_WAIT;
      end
      S_HDR_WAIT: begin
        if (memRspValid) begin
          if (stCountZero) begin
            nxt = S_IDLE;
          end else begin
            strb.enterHdr = 1'b1;
            nxt           = S_KEY_REQ;
          end
        end
      end
      S_KEY_REQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_KEY;
        if (memReqReady) nxt = S_KEY_WAIT;
      end
      S_KEY_WAIT: begin
        if (memRspValid) begin
          if (keyPtrMode) begin
            strb.capRow = 1'b1;
            nxt         = S_ROW_REQ;
          end else if (stKeyMatch) begin
            nxt = S_PAY_REQ;
          end else begin
            nxt = S_NEXT_REQ;
          end
        end
      end
      S_ROW_REQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_ROW;
        if (memReqReady) nxt = S_ROW_WAIT;
      end
      S_ROW_WAIT: begin
        if (memRspValid) begin
          nxt = stKeyMatch ? S_PAY_REQ : S_NEXT_REQ;
        end
      end
      S_PAY_REQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_PAY;
        if (memReqReady) nxt = S_PAY_WAIT;
      end
      S_PAY_WAIT: begin
        if (memRspValid) begin
          strb.capPay = 1'b1;
          nxt         = S_EMIT;
        end
      end
      S_EMIT: begin
        if (stOutFree) begin
          strb.loadOut = 1'b1;
          nxt          = S_NEXT_REQ;
        end
      end
      S_NEXT_REQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_NEXT;
        if (memReqReady) nxt = S_NEXT_WAIT;
      end
      S_NEXT_WAIT: begin
        if (memRspValid) begin
          if (stNextNull) begin
            nxt = S_DRAIN;
          end else begin
            strb.followNext = 1'b1;
            nxt             = S_KEY_REQ;
          end
        end
      end
      S_DRAIN: begin
        if (stOutFree) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign idle    = (state == S_IDLE);
  assign inReady = idle;

endmodule

// File: rtl/bucket_walker.sv
module bucket_walker
  import bwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgKeyPtr,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inKey,
  input  logic [ADDR_W-1:0] inBucket,
  input  logic [TAG_W-1:0]  inTag,
  output logic              idle,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              outValid,
  input  logic              outReady,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outPayload
);

  ctrlStrobe_t strb;
  logic        stKeyMatch;
  logic        stCountZero;
  logic        stNextNull;
  logic        stOutFree;

  bwalk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .cfgKeyPtr   (cfgKeyPtr),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stKeyMatch  (stKeyMatch),
    .stCountZero (stCountZero),
    .stNextNull  (stNextNull),
    .stOutFree   (stOutFree),
    .inReady     (inReady),
    .idle        (idle),
    .memReqValid (memReqValid),
    .strb        (strb)
  );

  bwalk_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inKey       (inKey),
    .inBucket    (inBucket),
    .inTag       (inTag),
    .memRspData  (memRspData),
    .outReady    (outReady),
    .memReqAddr  (memReqAddr),
    .outValid    (outValid),
    .outTag      (outTag),
    .outPayload  (outPayload),
    .stKeyMatch  (stKeyMatch),
    .stCountZero (stCountZero),
    .stNextNull  (stNextNull),
    .stOutFree   (stOutFree)
  );

endmodule

// File: rtl/bwalk_checker.sv
module bwalk_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              idle,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              outValid,
  input logic              outReady,
  input logic [TAG_W-1:0]  outTag,
  input logic [DATA_W-1:0] outPayload
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> !memReqValid); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outTag) && $stable(outPayload)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !memReqValid && !outValid); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady); // R2

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000); // R4

endmodule

bind bucket_walker bwalk_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/bucket_walker_bench.sv
`timescale 1ns/1ps
module bucket_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgKeyPtr = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inKey = '0;
  logic [31:0] inBucket = '0;
  logic [7:0]  inTag = '0;
  logic        idle;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outTag;
  logic [63:0] outPayload;

  always #4 clk = ~clk;

  bucket_walker u_bucket_walker (.*);

  logic [63:0] mem [0:1023];
  int          checkCnt = 0;
  int          failCnt = 0;
  int          readCnt = 0;
  int          recCnt = 0;
  logic [7:0]  recTag [0:63];
  logic [63:0] recPay [0:63];
  int          expCnt = 0;
  int          expReads = 0;
  logic [7:0]  expTag [0:63];
  logic [63:0] expPay [0:63];
  bit          bpMode = 1'b0;
  bit          stallAll = 1'b0;
  int          pendCnt = 0;
  logic [63:0] pendData = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nodeBase(input int i);
    return (i == 0) ? 17 : 100 - 4 * i;
  endfunction

  // Memory model: ready decided first, then the handshake is predicted
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = pendData;
        end
      end
      memReqReady = ($urandom % 4) != 0;
      if (rstN && memReqValid && memReqReady) begin
        readCnt++;
        pendData = mem[memReqAddr[12:3]];
        pendCnt  = 1 + int'($urandom % 4);
      end
    end
  end

  // Record writer model
  initial begin
    forever begin
      @(negedge clk);
      if (stallAll) outReady = 1'b0;
      else if (bpMode) outReady = ($urandom % 3) == 0;
      else outReady = 1'b1;
      if (rstN && outValid && outReady && recCnt < 64) begin
        recTag[recCnt] = outTag;
        recPay[recCnt] = outPayload;
        recCnt++;
      end
    end
  end

  task automatic buildBucket(input int nNodes, input logic [63:0] probe, input bit keyPtr,
                             input logic [7:0] mask, input logic [7:0] tag);
    mem[16]  = {48'h5A5A_C3C3_0F0F, 16'(nNodes)};
    expCnt   = 0;
    expReads = 1;
    if (nNodes == 0) begin
      mem[17] = probe;
      mem[18] = 64'(nodeBase(1) * 8);
      mem[19] = 64'hDEAD;
    end
    for (int i = 0; i < nNodes; i++) begin
      int          b;
      bit          hit;
      logic [63:0] k;
      b   = nodeBase(i);
      hit = mask[i];
      k   = hit ? probe : probe ^ (64'h1 << ((i * 13 + 5) % 64));
      if (keyPtr) begin
        mem[200 + i] = k;
        mem[b]       = 64'((200 + i) * 8);
      end else begin
        mem[b] = k;
      end
      mem[b + 1] = (i == nNodes - 1) ? 64'h0 : 64'(nodeBase(i + 1) * 8);
      mem[b + 2] = {8'hB0, tag, 16'h0, 32'(i * 7 + 1)};
      expReads += 2 + (keyPtr ? 1 : 0) + (hit ? 1 : 0);
      if (hit) begin
        expTag[expCnt] = tag;
        expPay[expCnt] = mem[b + 2];
        expCnt++;
      end
    end
  endtask

  task automatic runProbe(input logic [63:0] probe, input logic [7:0] tag, input bit keyPtr,
                          input int stallCycles, input string req);
    int guard;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    recCnt    = 0;
    readCnt   = 0;
    cfgKeyPtr = keyPtr;
    inValid   = 1'b1;
    inKey     = probe;
    inBucket  = 32'(16 * 8);
    inTag     = tag;
    @(negedge clk);
    inValid   = 1'b0;
    inKey     = ~probe;
    cfgKeyPtr = ~keyPtr;
    check(inReady == 1'b0, "R2", "inReady during walk", 64'(inReady), 64'h0);
    if (stallCycles > 0) begin
      repeat (stallCycles) @(negedge clk);
      check(outValid && !idle, "R10", "held record under stall",
            64'({outValid, idle}), 64'h2);
      check(outTag == tag && outPayload == expPay[0], "R10", "stalled record content",
            outPayload, expPay[0]);
      stallAll = 1'b0;
    end
    guard = 0;
    while (!idle && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, req, "walk finished", 64'(guard), 64'h0);
    check(recCnt == expCnt, req, "record count", 64'(recCnt), 64'(expCnt));
    for (int i = 0; i < expCnt && i < recCnt; i++) begin
      check(recTag[i] == expTag[i] && recPay[i] == expPay[i], req, "record content",
            recPay[i], expPay[i]);
    end
    check(readCnt == expReads, req, "memory read count", 64'(readCnt), 64'(expReads));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 1024; i++) mem[i] = 64'h0;
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    check(idle && inReady && !memReqValid && !outValid, "R1", "in reset",
          64'({idle, inReady, memReqValid, outValid}), 64'hC);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(idle == 1'b1, "R1", "idle after reset", 64'(idle), 64'h1);
    check(inReady == 1'b1, "R1", "inReady after reset", 64'(inReady), 64'h1);
    check(!memReqValid && !outValid, "R1", "quiet after reset",
          64'({memReqValid, outValid}), 64'h0);

    // R3: zero item count ends the walk after the header read
    buildBucket(0, 64'h1234_5678_9ABC_DEF0, 1'b0, 8'hFF, 8'h11);
    runProbe(64'h1234_5678_9ABC_DEF0, 8'h11, 1'b0, 0, "R3");

    // R4: single node taken from the header itself
    buildBucket(1, 64'hCAFE_0000_0000_0001, 1'b0, 8'h01, 8'h22);
    runProbe(64'hCAFE_0000_0000_0001, 8'h22, 1'b0, 0, "R4");

    // R5: chain of five with mixed matches
    buildBucket(5, 64'h0BAD_F00D_0000_0005, 1'b0, 8'h16, 8'h33);
    runProbe(64'h0BAD_F00D_0000_0005, 8'h33, 1'b0, 0, "R5");

    // R6: every node matches, order preserved
    bpMode = 1'b1;
    buildBucket(4, 64'h7777_0000_1111_2222, 1'b0, 8'h0F, 8'h44);
    runProbe(64'h7777_0000_1111_2222, 8'h44, 1'b0, 0, "R6");
    bpMode = 1'b0;

    // R8: no match, no payload reads
    buildBucket(6, 64'h5555_AAAA_5555_AAAA, 1'b0, 8'h00, 8'h55);
    runProbe(64'h5555_AAAA_5555_AAAA, 8'h55, 1'b0, 0, "R8");

    // R7: key-pointer mode with extra row reads
    buildBucket(4, 64'h0123_4567_89AB_CDEF, 1'b1, 8'h05, 8'h66);
    runProbe(64'h0123_4567_89AB_CDEF, 8'h66, 1'b1, 0, "R7");

    // R10: writer stalled for a long time mid-walk
    stallAll = 1'b1;
    buildBucket(3, 64'hFEED_FACE_0000_0003, 1'b0, 8'h07, 8'h77);
    runProbe(64'hFEED_FACE_0000_0003, 8'h77, 1'b0, 300, "R10");

    // R9: random buckets, random latency and ready patterns
    for (int t = 0; t < 40; t++) begin
      int          n;
      logic [63:0] k;
      logic [7:0]  m;
      bit          kp;
      n      = int'($urandom % 8);
      k      = {$urandom, $urandom};
      m      = 8'($urandom);
      kp     = 1'($urandom);
      bpMode = t[0];
      buildBucket(n, k, kp, m, 8'(t + 32));
      runProbe(k, 8'(t + 32), kp, 0, "R9");
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule